// File: doc/BRIEF.md
# Half-Rate Two-Stage Input Synchronizer

This block carries one asynchronous input bit into the clock domain of a downstream state machine. It uses a chain of two flip-flops. The raw input enters the first register, and the first register feeds the second. Only the second register's value leaves the block. All registers update on the falling edge of the system clock.

The chain does not advance on every falling edge. A two-state phase machine divides the clock by two and raises an enable on every second falling edge. The chain moves only on those enabled edges. A first stage that caught the input mid-transition, and went metastable or produced a runt level, therefore has two full clock periods to settle before the second stage samples it. No divided clock net is created.

A second small state machine watches the synchronized level. It raises `sync_valid` for exactly one cycle, on the falling edge after the output changed. The downstream machine can use it as an event flag.

Top module: `half_rate_sync`

States and transitions:
- The phase machine has two states. `PH_REST` moves to `PH_FIRE` and `PH_FIRE` moves back to `PH_REST` on every falling edge. The enable is high in `PH_FIRE`.
- The strobe machine has two states, `SV_QUIET` and `SV_FLAG`. Either state moves to `SV_FLAG` when the synchronized level differs from the copy held one edge earlier. Otherwise it moves to `SV_QUIET`.

## Requirements
- R1: `rst` is synchronous and active high, and is sampled on the falling clock edge. After one such edge with `rst` high, `sync_out` and `sync_valid` are 0, and the phase machine is in `PH_REST`.
- R2: Number the falling edges after `rst` is released 1, 2, 3 and so on. Only the even-numbered edges are enabled, and `sync_out` changes only on an even-numbered edge.
- R3: After an enabled edge numbered e, `sync_out` equals the value `async_in` had at edge e-2. Edges numbered 0 or below count as 0. A level change applied before edge k+1 is therefore seen on `sync_out` after edge k+3 when k+1 is even, and after edge k+4 when k+1 is odd.
- R4: An input level that is present only across non-enabled edges never reaches `sync_out`.
- R5: A pulse on `async_in` keeps `sync_out` at the pulse level for exactly two clock cycles for each enabled edge the pulse spans.
- R6: `sync_valid` is high for exactly one cycle, right after the falling edge that follows a change of `sync_out`. It is low at all other times.
- R7: Once `sync_out` changes, it holds its new value for at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| async_in | input | 1 | Raw asynchronous input bit |
| sync_out | output | 1 | Synchronized level (second stage) for the downstream state machine |
| sync_valid | output | 1 | One-cycle flag raised on the edge after `sync_out` changed |

## Verification
The hardest case to reach from the ports is a short pulse that covers only non-enabled edges. The phase is internal, so the stimulus must know it to place that pulse. The bench counts falling edges since reset release and aligns each pulse to a chosen edge parity. It sweeps both idle polarities, both parities and pulse lengths from one to five cycles. For each case it computes the expected time spent at the pulse level from how many even-numbered edges the pulse covers. A running model then predicts `sync_out` and `sync_valid` from the input recorded at each falling edge.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    // Phase of the divide-by-two enable generator.
    typedef enum logic [0:0] {
        PH_REST = 1'b0,
        PH_FIRE = 1'b1
    } phase_e;

    // State of the change-strobe generator.
    typedef enum logic [0:0] {
        SV_QUIET = 1'b0,
        SV_FLAG  = 1'b1
    } strobe_e;

    localparam int unsigned MIN_STAGES = 2;

endpackage

// File: rtl/hrs_enable_div.sv
module hrs_enable_div
    import hrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic en
);

    phase_e ph_q;
    phase_e ph_d;

    // State register: falling edge, synchronous reset.
    always_ff @(negedge clk) begin
        if (rst) begin
            ph_q <= PH_REST;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Next-state logic: the two phases alternate.
    always_comb begin
        unique case (ph_q)
            PH_REST: ph_d = PH_FIRE;
            PH_FIRE: ph_d = PH_REST;
            default: ph_d = PH_REST;
        endcase
    end

    // Output logic.
    always_comb begin
        en = (ph_q == PH_FIRE);
    end

    // R2: an enabled edge is always followed by a non-enabled one.
    p_enable_drop_r2: assert property (@(negedge clk) disable iff (rst)
        en |=> !en);

    // R2: a non-enabled edge is always followed by an enabled one.
    p_enable_rise_r2: assert property (@(negedge clk) disable iff (rst)
        !en |=> en);

endmodule

// File: rtl/hrs_sync_chain.sv
module hrs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);

    localparam int unsigned LAST = STAGES - 1;

    // Bit 0 is the stage that may go metastable. Higher bits give it time to settle.
    logic [LAST:0] stg_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else if (en) begin
            stg_q <= {stg_q[LAST-1:0], din};
        end
    end

    always_comb begin
        dout = stg_q[LAST];
    end

    // R2: the chain does not move on a non-enabled edge.
    p_hold_idle_r2: assert property (@(negedge clk) disable iff (rst)
        !en |=> $stable(stg_q));

    // R3: on an enabled edge the last stage takes the settled stage before it.
    p_shift_r3: assert property (@(negedge clk) disable iff (rst)
        en |=> (stg_q[LAST] == $past(stg_q[LAST-1])));

    // R3: on an enabled edge the first stage takes the raw input.
    p_capture_r3: assert property (@(negedge clk) disable iff (rst)
        en |=> (stg_q[0] == $past(din)));

endmodule

// File: rtl/hrs_change_strobe.sv
module hrs_change_strobe
    import hrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic flag
);

    strobe_e st_q;
    strobe_e st_d;
    logic    seen_q;

    // State register and the copy of the level from one edge earlier.
    always_ff @(negedge clk) begin
        if (rst) begin
            st_q   <= SV_QUIET;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            seen_q <= lvl;
        end
    end

    // Next-state logic.
    always_comb begin
        unique case (st_q)
            SV_QUIET: st_d = (lvl != seen_q) ? SV_FLAG : SV_QUIET;
            SV_FLAG:  st_d = (lvl != seen_q) ? SV_FLAG : SV_QUIET;
            default:  st_d = SV_QUIET;
        endcase
    end

    // Output logic.
    always_comb begin
        flag = (st_q == SV_FLAG);
    end

    // R6: the flag is raised only on an edge where the level had just changed.
    p_flag_cause_r6: assert property (@(negedge clk) disable iff (rst)
        $rose(flag) |-> (seen_q != $past(seen_q)));

endmodule

// File: rtl/half_rate_sync.sv
module half_rate_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out,
    output logic sync_valid
);

    logic stage_en;
    logic lvl;

    hrs_enable_div u_div (
        .clk (clk),
        .rst (rst),
        .en  (stage_en)
    );

    hrs_sync_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk  (clk),
        .rst  (rst),
        .en   (stage_en),
        .din  (async_in),
        .dout (lvl)
    );

    hrs_change_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .flag (sync_valid)
    );

    always_comb begin
        sync_out = lvl;
    end

    initial begin
        a_depth_r3: assert (STAGES >= hrs_pkg::MIN_STAGES)
            else $error("synchronizer needs at least two stages");
    end

    // R1: outputs are clear on the first edge after reset is released.
    p_reset_clear_r1: assert property (@(negedge clk) disable iff (rst)
        $fell(rst) |-> (!sync_out && !sync_valid));

    // R7: a change of the output is never undone on the next edge.
    p_no_glitch_r7: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && (sync_out != $past(sync_out))) |=> (sync_out == $past(sync_out)));

    // R6: every change of the output is flagged on the following edge.
    p_flag_follows_r6: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && (sync_out != $past(sync_out))) |=> sync_valid);

    // R6: the flag lasts a single cycle.
    p_flag_single_r6: assert property (@(negedge clk) disable iff (rst)
        sync_valid |=> !sync_valid);

endmodule

// File: tb/half_rate_sync_bench.sv
`timescale 1ns/1ps
module half_rate_sync_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic async_in = 1'b0;
    logic sync_out;
    logic sync_valid;

    int n_chk = 0;
    int n_bad = 0;
    int nedge = 0;
    bit finished = 1'b0;
    logic hist [8];

    always #2.5 clk = ~clk;

    half_rate_sync u_half_rate_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (async_in),
        .sync_out   (sync_out),
        .sync_valid (sync_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, nedge);
        end
    endtask

    // Number the falling edges since reset release, and record the input at each one.
    always @(negedge clk) begin
        if (rst) begin
            nedge <= 0;
        end else begin
            hist[(nedge + 1) % 8] <= async_in;
            nedge <= nedge + 1;
        end
    end

    // Running model, sampled on the rising edge, away from the active edge.
    logic p1 = 1'b0;
    logic p2 = 1'b0;
    always @(posedge clk) begin
        if (rst || nedge == 0) begin
            p1 = 1'b0;
            p2 = 1'b0;
        end else begin
            int m;
            logic e;
            m = (nedge - (nedge % 2)) - 2;
            e = (m >= 1) ? hist[m % 8] : 1'b0;
            chk(sync_out === e, "R3", int'(sync_out), int'(e));
            if (sync_out != p1) begin
                chk((nedge % 2) == 0, "R2", nedge % 2, 0);
            end
            if (nedge >= 3) begin
                chk(sync_valid === (p1 != p2), "R6", int'(sync_valid), int'(p1 != p2));
                if (sync_out != p1) begin
                    chk(p1 == p2, "R7", int'(p2), int'(p1));
                end
            end
            p2 = p1;
            p1 = sync_out;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: outputs are clear after reset.
        repeat (3) @(posedge clk);
        chk(sync_out === 1'b0, "R1", int'(sync_out), 0);
        chk(sync_valid === 1'b0, "R1", int'(sync_valid), 0);
        rst = 1'b0;
        repeat (4) @(posedge clk);

        // R3: latency of a level step, both directions and both edge parities.
        for (int dir = 0; dir < 2; dir++) begin
            for (int ph = 0; ph < 2; ph++) begin
                int k;
                int first;
                logic old_v;
                logic new_v;
                old_v = (dir == 1);
                new_v = (dir == 0);
                async_in = old_v;
                repeat (8) @(posedge clk);
                while ((nedge % 2) != ph) @(posedge clk);
                k = nedge;
                first = (((k + 1) % 2) == 0) ? k + 3 : k + 4;
                async_in = new_v;
                while (nedge < first) begin
                    @(posedge clk);
                    if (nedge == first - 1) begin
                        chk(sync_out === old_v, "R3 before", int'(sync_out), int'(old_v));
                    end
                end
                chk(sync_out === new_v, "R3 arrival", int'(sync_out), int'(new_v));
            end
        end

        // R4, R5: pulse sweep over idle polarity, start parity and length.
        for (int idle = 0; idle < 2; idle++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int len = 1; len <= 5; len++) begin
                    int k;
                    int cnt;
                    int evens;
                    logic idle_v;
                    idle_v = (idle == 1);
                    async_in = idle_v;
                    repeat (8) @(posedge clk);
                    while ((nedge % 2) != ph) @(posedge clk);
                    k = nedge;
                    evens = ((k + len) / 2) - (k / 2);
                    cnt = 0;
                    async_in = ~idle_v;
                    for (int i = 1; i <= len + 8; i++) begin
                        @(posedge clk);
                        if (sync_out !== idle_v) cnt++;
                        if (i == len) async_in = idle_v;
                    end
                    chk(cnt == 2 * evens, "R5", cnt, 2 * evens);
                    if (evens == 0) begin
                        chk(cnt == 0, "R4", cnt, 0);
                    end
                end
            end
        end

        // R1: a reset in mid-run clears a high output on the next falling edge.
        async_in = 1'b1;
        repeat (10) @(posedge clk);
        chk(sync_out === 1'b1, "R3 settle", int'(sync_out), 1);
        rst = 1'b1;
        @(posedge clk);
        chk(sync_out === 1'b0, "R1", int'(sync_out), 0);
        chk(sync_valid === 1'b0, "R1", int'(sync_valid), 0);
        @(posedge clk);
        rst = 1'b0;
        repeat (5) @(posedge clk);
        chk(sync_out === 1'b1, "R3 after reset", int'(sync_out), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule